// File: doc/BRIEF.md
# Serial Flash Command Engine

This block runs serial-flash transactions over an SPI bus in mode 3. Software loads an address register and a data register, then writes a command word. That write starts one frame on the bus. The frame sends an opcode byte, up to three address bytes and up to fifteen zero dummy bytes. It ends with a data phase of up to four bytes that are either sent or received through the 32-bit data register. A status register shows whether a frame is still running and whether a command was refused.

A keep-selected bit in the command leaves chip select asserted when a frame ends. A long flash access can then be built from many short frames. The opcode goes out only in the frame that asserts chip select, so the later frames carry only their data. A command with nothing to shift and the keep bit clear simply closes the transaction. A separate divider register sets the serial clock period in steps of two engine-clock cycles.

Top module: `sfc_engine`

## Requirements
- R1: After reset the status register reads 0, every chip-select line is high, `sck` is high, `mosi` is low and the divider register reads 1.
- R2: Register offsets are 0 command, 1 address, 2 data, 3 status and 4 divider. The command word has these fields: opcode in bits 7:0, data length in bits 10:8, address length in bits 12:11, dummy length in bits 16:13, write direction in bit 17, keep-selected in bit 18 and chip-select number in bits 20:19. A frame shifts its bytes in this order: opcode (only when chip select is not already held), address, dummy, data. Each byte goes most significant bit first. A command whose only content is the opcode is legal and sends that byte alone.
- R3: Address length 0 to 3 sends that many low bytes of the address register, most significant of them first.
- R4: Dummy length 0 to 15 sends that many bytes of zero after the address.
- R5: In a write frame (bit 17 set), data length 0 to 4 sends data-register bytes starting with bits 7:0, then bits 15:8 and upward.
- R6: In a read frame (bit 17 clear), `mosi` is low for the whole data phase. The received bytes land in the data register packed from bits 7:0 upward, and the unused upper bytes read as zero by the time pending clears.
- R7: With keep-selected set, chip select stays low after the frame ends, and the next frame omits the opcode.
- R8: With keep-selected clear, chip select goes high after the last bit. A command with zero bytes to shift, issued while chip select is held, releases it at once without clocking and without setting pending.
- R9: `sck` idles high. `mosi` changes only together with a falling edge of `sck`, and `miso` is sampled at the rising edge.
- R10: The divider value i sets `sck` low for i clock cycles and then high for i cycles. A written value of 0 is stored as 1 and 7 is stored as 6, and reads return the stored value.
- R11: Status bit 0 (pending) is set from the clock edge that accepts a command until the frame's last bit completes. Writes to the address or data register while pending is set are ignored.
- R12: Status bit 1 (error) is set by a command write while pending, and such a write leaves the running frame unchanged. It is also set by a data length above 4 or a chip-select number not below the number of lines. In those two cases no frame starts.
- R13: Writing status with bit 1 set clears the error bit. Writing it with bit 1 clear leaves the error bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Engine clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| sck | output | 1 | Serial clock, idles high |
| cs_n | output | NCS | Active-low chip selects |
| mosi | output | 1 | Serial data to the flash |
| miso | input | 1 | Serial data from the flash |

## Verification
The hardest case to reach is a transaction that spans frames. Chip select must stay low between frames, the second frame must leave out its opcode, and a final empty command must release the line without a single clock. The bench issues three back-to-back commands on one held chip select and compares the bits captured on each frame separately. A second hard case is a command that arrives while a frame is still shifting. The bench writes new data and a new command right after the first command is accepted. It then checks that the error flag rises and that the bytes on the bus still match the original data.

// File: rtl/sfc_engine.sv
module sfc_engine #(
  parameter int NCS = 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_we,
  input  logic [2:0]     reg_addr,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  output logic           sck,
  output logic [NCS-1:0] cs_n,
  output logic           mosi,
  input  logic           miso
);
  localparam logic [2:0] A_CMD = 3'd0, A_ADR = 3'd1, A_DAT = 3'd2, A_STA = 3'd3, A_DIV = 3'd4;

  logic [20:0] cmd_q;
  logic [23:0] addr_q;
  logic [31:0] data_q;
  logic [7:0]  rxsh_q;
  logic [4:0]  bidx_q;
  logic [2:0]  bit_q, div_q;
  logic [3:0]  cnt_q;
  logic        busy_q, err_q, held_q, opc_q, sck_q;

  wire [1:0] alen = cmd_q[12:11];
  wire [3:0] dum  = cmd_q[16:13];
  wire [2:0] dlen = cmd_q[10:8];
  wire       wr   = cmd_q[17];
  wire       keep = cmd_q[18];

  wire [4:0] e_op = {4'd0, opc_q};
  wire [4:0] e_ad = e_op + {3'd0, alen};
  wire [4:0] e_du = e_ad + {1'b0, dum};
  wire [4:0] tot  = e_du + {2'd0, dlen};

  wire       cmd_wr = reg_we && reg_addr == A_CMD;
  wire [4:0] n_tot  = {4'd0, !held_q} + {3'd0, reg_wdata[12:11]} + {1'b0, reg_wdata[16:13]}
                      + {2'd0, reg_wdata[10:8]};
  wire       bad    = busy_q || reg_wdata[10:8] > 3'd4 || 32'(reg_wdata[20:19]) >= NCS;
  wire       go     = cmd_wr && !bad && n_tot != 5'd0;
  wire       fin0   = cmd_wr && !bad && n_tot == 5'd0;

  wire [3:0] half_end = {1'b0, div_q} - 4'd1;
  wire [3:0] full_end = {div_q, 1'b0} - 4'd1;
  wire       in_data  = bidx_q >= e_du;
  wire [1:0] ai       = 2'(alen - 2'd1 - 2'(bidx_q - e_op));
  wire [1:0] di       = 2'(bidx_q - e_du);
  wire [23:0] a_sh    = addr_q >> {ai, 3'b000};
  wire [31:0] d_sh    = data_q >> {di, 3'b000};

  logic [7:0] cur;
  always_comb begin
    if (bidx_q < e_op)      cur = cmd_q[7:0];
    else if (bidx_q < e_ad) cur = a_sh[7:0];
    else if (bidx_q < e_du) cur = 8'h00;
    else                    cur = wr ? d_sh[7:0] : 8'h00;
  end

  assign mosi = busy_q && cur[3'd7 - bit_q];
  assign sck  = sck_q;

  for (genvar j = 0; j < NCS; j++) begin : g_cs
    assign cs_n[j] = !(held_q && 32'(cmd_q[20:19]) == j);
  end

  always_comb begin
    case (reg_addr)
      A_CMD:   reg_rdata = {11'd0, cmd_q};
      A_ADR:   reg_rdata = {8'd0, addr_q};
      A_DAT:   reg_rdata = data_q;
      A_STA:   reg_rdata = {30'd0, err_q, busy_q};
      A_DIV:   reg_rdata = {29'd0, div_q};
      default: reg_rdata = 32'd0;
    endcase
  end

  wire unused_wdata = &{1'b0, reg_wdata[31:24]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0; addr_q <= '0; data_q <= '0; rxsh_q <= '0;
      bidx_q <= '0; bit_q <= '0; div_q <= 3'd1; cnt_q <= '0;
      busy_q <= 1'b0; err_q <= 1'b0; held_q <= 1'b0; opc_q <= 1'b0; sck_q <= 1'b1;
    end else begin
      if (reg_we && reg_addr == A_STA && reg_wdata[1]) err_q <= 1'b0;
      if (cmd_wr && bad) err_q <= 1'b1;
      if (reg_we && reg_addr == A_DIV)
        div_q <= (reg_wdata[2:0] == 3'd0) ? 3'd1 : (reg_wdata[2:0] == 3'd7) ? 3'd6 : reg_wdata[2:0];
      if (reg_we && reg_addr == A_ADR && !busy_q) addr_q <= reg_wdata[23:0];
      if (reg_we && reg_addr == A_DAT && !busy_q) data_q <= reg_wdata;
      if (go) begin
        cmd_q  <= reg_wdata[20:0];
        opc_q  <= !held_q;
        held_q <= 1'b1;
        busy_q <= 1'b1;
        cnt_q  <= '0;
        bidx_q <= '0;
        bit_q  <= '0;
        sck_q  <= 1'b0;
        if (!reg_wdata[17]) data_q <= '0;
      end else if (fin0) begin
        cmd_q  <= reg_wdata[20:0];
        held_q <= reg_wdata[18];
      end else if (busy_q) begin
        if (cnt_q == half_end) begin
          sck_q  <= 1'b1;
          rxsh_q <= {rxsh_q[6:0], miso};
        end
        if (cnt_q == full_end) begin
          cnt_q <= '0;
          if (bit_q == 3'd7 && in_data && !wr)
            for (int j = 0; j < 4; j++)
              if (di == 2'(j)) data_q[8*j +: 8] <= rxsh_q;
          if (bit_q == 3'd7 && bidx_q == tot - 5'd1) begin
            busy_q <= 1'b0;
            held_q <= keep;
          end else begin
            sck_q <= 1'b0;
            bit_q <= bit_q + 3'd1;
            if (bit_q == 3'd7) bidx_q <= bidx_q + 5'd1;
          end
        end else begin
          cnt_q <= cnt_q + 4'd1;
        end
      end
    end
  end

  a_r9_sck_idle_high: assert property (@(posedge clk) disable iff (!rst_n) !busy_q |-> sck);
  a_r9_mosi_still_on_rise: assert property (@(posedge clk) disable iff (!rst_n) $rose(sck) |-> $stable(mosi));
  a_r12_busy_write_errs: assert property (@(posedge clk) disable iff (!rst_n) (cmd_wr && busy_q) |=> err_q);
  a_r8_cs_idle: assert property (@(posedge clk) disable iff (!rst_n) !held_q |-> &cs_n);
  a_r10_count_bound: assert property (@(posedge clk) disable iff (!rst_n) busy_q |-> cnt_q <= full_end);
  a_r11_pending_rises: assert property (@(posedge clk) disable iff (!rst_n) go |=> busy_q);
endmodule

// File: tb/sfc_engine_bench.sv
module sfc_engine_bench;
  logic clk = 0, rst_n = 0, reg_we = 0, miso;
  logic [2:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic sck, mosi;
  logic [0:0] cs_n;

  sfc_engine #(.NCS(1)) u_sfc_engine (.clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso));

  always #5 clk = ~clk;

  int nchk = 0, nerr = 0;
  logic cap [0:255];
  int ncap = 0, mcnt = 0;
  logic [0:255] pat = '0;
  logic [7:0] expb [0:31];
  int nexp = 0;

  assign miso = pat[mcnt[7:0]];
  always @(posedge sck) if (cs_n[0] == 1'b0 && ncap < 256) begin
    cap[ncap] = mosi; ncap++; mcnt++;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin nerr++; $display("FAIL %s actual=%h expected=%h", tag, act, exp); end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    reg_addr = a; #1; v = reg_rdata;
  endtask

  task automatic wait_done();
    logic [31:0] s;
    for (int k = 0; k < 5000; k++) begin
      rd(3, s); if (!s[0]) break;
      @(negedge clk);
    end
  endtask

  function automatic logic [31:0] mk(input logic [7:0] op, input int dl, input int al, input int dm,
                                      input bit w, input bit kp, input int cs);
    return {11'd0, 2'(cs), kp, w, 4'(dm), 2'(al), 3'(dl), op};
  endfunction

  task automatic clr(); ncap = 0; mcnt = 0; nexp = 0; endtask
  task automatic push(input logic [7:0] b); expb[nexp] = b; nexp++; endtask

  task automatic chk_stream(input string tag);
    int bad = 0;
    check(ncap == 8*nexp, {tag, " bit count"}, ncap, 8*nexp);
    if (ncap == 8*nexp)
      for (int k = 0; k < 8*nexp; k++) if (cap[k] !== expb[k/8][7 - k%8]) bad++;
    check(bad == 0, {tag, " bit stream"}, bad, 0);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(3, v); check(v == 0, "R1 status", v, 0);
    rd(4, v); check(v == 1, "R1 divider", v, 1);
    check(cs_n == 1'b1 && sck == 1'b1 && mosi == 1'b0, "R1 pins", {cs_n, sck, mosi}, 3'b110);
  endtask

  task automatic t_write();
    logic [31:0] v;
    clr();
    wr(1, 32'h00123456); wr(2, 32'hDDCCBBAA);
    wr(0, mk(8'h02, 4, 3, 0, 1, 0, 0));
    rd(3, v); check(v[0] == 1, "R11 pending after command", v, 1);
    check(cs_n == 0, "R2 cs low in frame", cs_n, 0);
    wait_done(); @(negedge clk);
    check(cs_n == 1, "R8 cs released", cs_n, 1);
    foreach (expb[i]) if (i < 0) expb[i] = 0;
    push(8'h02); push(8'h12); push(8'h34); push(8'h56);
    push(8'hAA); push(8'hBB); push(8'hCC); push(8'hDD);
    chk_stream("R3 R5 write frame");
  endtask

  task automatic t_read();
    logic [31:0] v;
    clr();
    pat = '1;
    pat[40:47] = 8'h5A; pat[48:55] = 8'hC3; pat[56:63] = 8'h81;
    wr(1, 32'h00ABCDEF); wr(2, 32'hFFFFFFFF);
    wr(0, mk(8'h0B, 3, 3, 1, 0, 0, 0));
    wait_done(); @(negedge clk);
    rd(2, v); check(v == 32'h0081C35A, "R6 read data packed", v, 32'h0081C35A);
    push(8'h0B); push(8'hAB); push(8'hCD); push(8'hEF);
    push(8'h00); push(8'h00); push(8'h00); push(8'h00);
    chk_stream("R4 R6 read frame mosi");
  endtask

  task automatic t_keep();
    logic [31:0] v;
    clr(); pat = '0; pat[8:15] = 8'h11; pat[16:23] = 8'h22;
    wr(0, mk(8'h9F, 2, 0, 0, 0, 1, 0));
    wait_done(); @(negedge clk);
    check(cs_n == 0, "R7 cs held after frame", cs_n, 0);
    rd(2, v); check(v == 32'h00002211, "R7 first frame data", v, 32'h00002211);
    push(8'h9F); push(8'h00); push(8'h00);
    chk_stream("R7 first frame");
    clr(); pat = '0; pat[0:7] = 8'h33;
    wr(0, mk(8'h9F, 1, 0, 0, 0, 1, 0));
    wait_done(); @(negedge clk);
    rd(2, v); check(v == 32'h33, "R7 second frame data", v, 32'h33);
    push(8'h00);
    chk_stream("R7 second frame no opcode");
    clr();
    wr(0, mk(8'h9F, 0, 0, 0, 0, 0, 0));
    rd(3, v); check(v[0] == 0, "R8 empty command not pending", v, 0);
    check(cs_n == 1, "R8 empty command releases cs", cs_n, 1);
    check(ncap == 0, "R8 empty command no clocks", ncap, 0);
  endtask

  task automatic t_short();
    clr();
    wr(0, mk(8'h06, 0, 0, 0, 1, 0, 0));
    wait_done(); @(negedge clk);
    push(8'h06);
    chk_stream("R2 opcode only");
    check(cs_n == 1, "R2 opcode only releases", cs_n, 1);
    clr();
    wr(1, 32'h00ABCDEF);
    wr(0, mk(8'h20, 0, 1, 0, 1, 0, 0));
    wait_done(); @(negedge clk);
    push(8'h20); push(8'hEF);
    chk_stream("R3 one address byte");
  endtask

  task automatic measure(output int lo, output int hi);
    lo = 0; hi = 0;
    for (int k = 0; k < 100 && sck; k++) @(negedge clk);
    for (int k = 0; k < 100 && !sck; k++) begin lo++; @(negedge clk); end
    for (int k = 0; k < 100 && sck; k++) begin hi++; @(negedge clk); end
  endtask

  task automatic t_div();
    logic [31:0] v;
    int lo, hi;
    wr(4, 3); rd(4, v); check(v == 3, "R10 divider readback", v, 3);
    clr();
    reg_we = 1; reg_addr = 0; reg_wdata = mk(8'hA5, 0, 0, 0, 1, 0, 0);
    @(negedge clk); reg_we = 0;
    measure(lo, hi);
    check(lo == 3, "R10 low phase", lo, 3);
    check(hi == 3, "R10 high phase", hi, 3);
    wait_done(); @(negedge clk);
    push(8'hA5);
    chk_stream("R9 bits at rising edges");
    check(sck == 1, "R9 idle high", sck, 1);
    wr(4, 7); rd(4, v); check(v == 6, "R10 clamp 7", v, 6);
    wr(4, 0); rd(4, v); check(v == 1, "R10 clamp 0", v, 1);
    clr();
    reg_we = 1; reg_addr = 0; reg_wdata = mk(8'hA5, 0, 0, 0, 1, 0, 0);
    @(negedge clk); reg_we = 0;
    measure(lo, hi);
    check(lo == 1 && hi == 1, "R10 divider 1 phases", {lo[15:0], hi[15:0]}, 32'h00010001);
    wait_done(); @(negedge clk);
  endtask

  task automatic t_error();
    logic [31:0] v;
    clr();
    wr(2, 32'h44332211);
    wr(0, mk(8'h02, 4, 0, 0, 1, 0, 0));
    wr(2, 32'h99999999);
    wr(0, mk(8'hFF, 1, 0, 0, 1, 0, 0));
    rd(3, v); check(v[1:0] == 2'b11, "R12 error while pending", v, 3);
    wait_done(); @(negedge clk);
    push(8'h02); push(8'h11); push(8'h22); push(8'h33); push(8'h44);
    chk_stream("R11 R12 frame unchanged");
    rd(2, v); check(v == 32'h44332211, "R11 data write ignored", v, 32'h44332211);
    wr(3, 0); rd(3, v); check(v[1] == 1, "R13 zero write keeps error", v, 2);
    wr(3, 2); rd(3, v); check(v[1] == 0, "R13 clear error", v, 0);
    clr();
    wr(0, mk(8'h03, 5, 0, 0, 0, 0, 0));
    rd(3, v); check(v == 2, "R12 length above 4", v, 2);
    repeat (4) @(negedge clk);
    check(cs_n == 1 && ncap == 0, "R12 no frame on length error", {cs_n, ncap[7:0]}, 9'h100);
    wr(3, 2);
    wr(0, mk(8'h03, 1, 0, 0, 0, 0, 1));
    rd(3, v); check(v == 2, "R12 bad chip select", v, 2);
    repeat (4) @(negedge clk);
    check(cs_n == 1 && ncap == 0, "R12 no frame on select error", {cs_n, ncap[7:0]}, 9'h100);
    wr(3, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_write();
    t_read();
    t_keep();
    t_short();
    t_div();
    t_error();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule